// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host side of a link to a serial successive-approximation analog-to-digital converter. A request carries a 2-bit channel number and a single-ended/differential mode bit. The controller then runs one complete read. It pulls chip select low and produces a serial clock whose two halves are each `HALF_DIV` system clocks long. It shifts out a start bit and a 4-bit input-selection word. It drops the single zero that the converter sends before its data, and it collects the 8-bit result most significant bit first. When `REPLAY_ON` is set, it also collects the seven extra bits that the converter sends back least significant bit first. These are put back in order and compared with the upper seven bits of the first reading.

After the last bit the controller raises chip select and keeps it high for one full serial period. It then gives one `result_valid` pulse. The result and the mismatch flag stay on the ports until the next read completes. `busy` is high from the accepted request up to and including the valid pulse, and any request made during that time is ignored. An elaboration check rejects a `HALF_DIV` whose half period, at `SYS_CLK_MHZ`, falls outside the range 300 ns to 60 µs. Because both halves have the same length, the duty cycle is always 50%.

The state machine has four states:
- `S_IDLE`: waits for a request.
- `S_FRAME`: chip select is low and the serial bits run.
- `S_GAP`: chip select is high for one serial period.
- `S_DONE`: lasts one cycle, gives the valid pulse and loads the result.

The transitions are:
- accept: `S_IDLE`→`S_FRAME` when `req` is high.
- frame_end: `S_FRAME`→`S_GAP` at the last half-period tick.
- gap_end: `S_GAP`→`S_DONE` after two half-period ticks.
- release: `S_DONE`→`S_IDLE`, unconditionally.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is asserted and in idle, `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0 and `result_valid`=0.
- R2: A request in idle is accepted at the next clock edge, and `cs_n` goes low after that edge. `busy` stays high from that edge through the valid cycle. A request made while `busy` is high starts no frame and does not change the result.
- R3: While `cs_n` is low the serial clock is low for `HALF_DIV` system clocks and then high for `HALF_DIV`, once per bit slot. While `cs_n` is high the serial clock stays low.
- R4: `mosi` changes only when `sclk` falls or while `sclk` is low. In slot 0 it carries a 1 (the start bit). Slots 1 to 4 carry, in order, the single-ended flag, the odd/sign bit, select1 and select0 (always 0). It is 0 in every later slot.
- R5: In single-ended mode (`diff_mode`=0) the four bits after the start bit are {1, chan[0], chan[1], 0}.
- R6: In differential mode (`diff_mode`=1) the four bits after the start bit are {0, chan[0], chan[1], 0}. Here chan[1] picks the pair {0,1} or {2,3}, and chan[0]=1 makes the odd channel of the pair the positive input.
- R7: `miso` is sampled on each rising `sclk` edge. The slot 5 sample (the leading zero) is dropped. The samples of slots 6 to 13 form `result`, first sample in bit 7.
- R8: With `REPLAY_ON`=1, the samples of slots 14 to 20 are taken as result bits 1 to 7 in that order. `mismatch` is 1 exactly when they differ from `result[7:1]`.
- R9: The frame lasts 2·`HALF_DIV`·SLOTS system clocks, where SLOTS is 21 with replay and 14 without. `cs_n` is then high for 2·`HALF_DIV` clocks before the valid cycle.
- R10: `result_valid` is high for one cycle, and `result` and `mismatch` hold their values until the next valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Start a read (taken only when idle) |
| chan | input | 2 | Channel number, or pair and polarity in differential mode |
| diff_mode | input | 1 | 1 selects differential input |
| busy | output | 1 | Read in progress |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Serial command to the converter |
| miso | input | 1 | Serial data from the converter |
| result | output | DATA_W | Converted code |
| result_valid | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Replay disagreed with the first reading |

## Verification
The assertions assume that `miso` only changes while `sclk` is low. They also assume that `req` is driven cleanly from a synchronous source, so that the state machine never leaves a frame early. The bench meets both assumptions with a behavioural converter model. The model updates `miso` only on falling `sclk` edges and starts its answer only after it has received the full 4-bit selection word. Requests are driven on system clock falling edges, including one request made deliberately in the middle of a frame.

// File: rtl/adc_rdr_pkg.sv
package adc_rdr_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FRAME,
        S_GAP,
        S_DONE
    } rdr_state_t;

    localparam int CMD_W = 5;

    // start bit, single-ended flag, odd/sign, select1, select0
    function automatic logic [CMD_W-1:0] make_cmd(input logic [1:0] ch, input logic diff);
        make_cmd = {1'b1, ~diff, ch[0], ch[1], 1'b0};
    endfunction

endpackage

// File: rtl/rdr_halftick.sv
module rdr_halftick #(
    parameter int HALF_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    generate
        if (HALF_DIV > 1) begin : g_tick_chk
            // R3: ticks are spaced HALF_DIV clocks apart, never back to back
            p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rdr_capture.sv
module rdr_capture #(
    parameter int DATA_W    = 8,
    parameter int REPLAY_ON = 1,
    parameter int FIRST     = 6,
    parameter int SLOT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [SLOT_W-1:0] slot,
    input  logic              miso,
    output logic [DATA_W-1:0] data,
    output logic              mism
);
    localparam int REP_W     = DATA_W - 1;
    localparam int DATA_LAST = FIRST + DATA_W - 1;
    localparam int REP_FIRST = FIRST + DATA_W;
    localparam int REP_LAST  = REP_FIRST + REP_W - 1;

    logic in_data;
    assign in_data = (slot >= SLOT_W'(FIRST)) && (slot <= SLOT_W'(DATA_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clear) begin
            data <= '0;
        end else if (sample && in_data) begin
            data <= {data[DATA_W-2:0], miso};
        end
    end

    generate
        if (REPLAY_ON != 0) begin : g_replay
            logic [REP_W-1:0] rep;
            logic             in_rep;
            assign in_rep = (slot >= SLOT_W'(REP_FIRST)) && (slot <= SLOT_W'(REP_LAST));

            // replay arrives bit1 first; shift in from the top to restore order
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rep <= '0;
                end else if (clear) begin
                    rep <= '0;
                end else if (sample && in_rep) begin
                    rep <= {miso, rep[REP_W-1:1]};
                end
            end
            assign mism = (rep != data[DATA_W-1:1]);

            // R8: the first-reading register is frozen while the replay is taken
            p_data_frozen_in_replay_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (sample && in_rep) |=> $stable(data));
        end else begin : g_no_replay
            assign mism = 1'b0;
        end
    endgenerate

    // R7: the leading-zero slot never disturbs the captured data
    p_lead_skipped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && slot == SLOT_W'(FIRST - 1) && !clear) |=> $stable(data));

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adc_rdr_pkg::*;
#(
    parameter int SYS_CLK_MHZ = 200,
    parameter int HALF_DIV    = 64,
    parameter int DATA_W      = 8,
    parameter int REPLAY_ON   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        chan,
    input  logic              diff_mode,
    output logic              busy,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              mismatch
);
    localparam int LEAD_SLOT  = CMD_W;
    localparam int DATA_FIRST = CMD_W + 1;
    localparam int SLOTS      = DATA_FIRST + DATA_W + ((REPLAY_ON != 0) ? DATA_W - 1 : 0);
    localparam int HALF_W     = $clog2(2 * SLOTS);
    localparam int SLOT_W     = HALF_W - 1;
    localparam int HALF_NS    = (HALF_DIV * 1000) / SYS_CLK_MHZ;
    localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(2 * SLOTS - 1);

    generate
        if (HALF_NS < 300 || HALF_NS > 60000) begin : g_bad_divider
            $error("HALF_DIV gives a serial half period outside 300 ns .. 60 us");
        end
    endgenerate

    rdr_state_t         state, nxt;
    logic [HALF_W-1:0]  half_idx;
    logic [CMD_W-1:0]   cmd_sh;
    logic               tick;
    logic               run;
    logic               accept;
    logic               sample;
    logic [DATA_W-1:0]  cap_data;
    logic               cap_mism;

    assign run    = (state == S_FRAME) || (state == S_GAP);
    assign accept = (state == S_IDLE) && req;
    assign sample = (state == S_FRAME) && tick && !half_idx[0];

    rdr_halftick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    rdr_capture #(
        .DATA_W    (DATA_W),
        .REPLAY_ON (REPLAY_ON),
        .FIRST     (DATA_FIRST),
        .SLOT_W    (SLOT_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .sample (sample),
        .slot   (half_idx[HALF_W-1:1]),
        .miso   (miso),
        .data   (cap_data),
        .mism   (cap_mism)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (req) nxt = S_FRAME;
            S_FRAME: if (tick && half_idx == LAST_HALF) nxt = S_GAP;
            S_GAP:   if (tick && half_idx[0]) nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            half_idx <= '0;
            cmd_sh   <= '0;
            result   <= '0;
            mismatch <= 1'b0;
        end else begin
            state <= nxt;
            unique case (state)
                S_IDLE: begin
                    if (req) begin
                        half_idx <= '0;
                        cmd_sh   <= make_cmd(chan, diff_mode);
                    end
                end
                S_FRAME: begin
                    if (tick) begin
                        half_idx <= (half_idx == LAST_HALF) ? '0 : half_idx + 1'b1;
                        if (half_idx[0]) cmd_sh <= {cmd_sh[CMD_W-2:0], 1'b0};
                    end
                end
                S_GAP: begin
                    if (tick) begin
                        half_idx <= half_idx + 1'b1;
                        if (half_idx[0]) begin
                            result   <= cap_data;
                            mismatch <= cap_mism;
                        end
                    end
                end
                S_DONE: begin
                    half_idx <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cs_n         = (state != S_FRAME);
        sclk         = (state == S_FRAME) && half_idx[0];
        mosi         = (state == S_FRAME) && cmd_sh[CMD_W-1];
        busy         = (state != S_IDLE);
        result_valid = (state == S_DONE);
    end

    // R3: serial clock is parked low whenever chip select is released
    p_sclk_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2: a frame only opens from an idle request
    p_open_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(req) && !$past(busy)));

    // R4: command line steady through every high half of the serial clock
    p_mosi_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R9: valid only after chip select has been high
    p_gap_before_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (cs_n && $past(cs_n)));

    // R10: single-cycle pulse
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R10: outputs hold outside the valid cycle
    p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(result) && $stable(mismatch)));

endmodule

// File: tb/sim_adc_serial_reader.sv
`timescale 1ns/1ps
module sim_adc_serial_reader;
    localparam int H        = 64;
    localparam int N        = 21;
    localparam int FRAME_C  = 2 * N * H;
    localparam int DONE_C   = FRAME_C + 2 * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [1:0] chan = 2'd0;
    logic diff_mode = 1'b0;
    logic busy, cs_n, sclk, mosi, result_valid, mismatch;
    logic miso = 1'b0;
    logic [7:0] result;

    integer n_checks = 0;
    integer n_fail   = 0;
    integer cycles   = 0;

    always #2.5 clk = ~clk;

    adc_serial_reader #(.SYS_CLK_MHZ(200), .HALF_DIV(H), .DATA_W(8), .REPLAY_ON(1)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .chan(chan), .diff_mode(diff_mode),
        .busy(busy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
        .result(result), .result_valid(result_valid), .mismatch(mismatch)
    );

    // ---------------- behavioural converter model ----------------
    logic [7:0] dev_code = 8'h00;
    bit         dev_corrupt = 1'b0;
    bit         dev_started = 1'b0;
    integer     dev_nb = 0;
    integer     dev_falls = 0;
    integer     dev_opens = 0;
    integer     dev_extra = 0;
    integer     dev_first_rise = -1;
    logic [3:0] dev_addr = 4'h0;

    always @(negedge cs_n) begin
        dev_opens++;
        dev_addr = 4'h0;
        dev_first_rise = -1;
    end

    always @(posedge cs_n) begin
        dev_started = 1'b0;
        dev_nb = 0;
        dev_falls = 0;
        miso = 1'b0;
    end

    always @(posedge sclk) begin
        if (cs_n === 1'b0) begin
            if (dev_first_rise < 0) dev_first_rise = (mosi === 1'b1) ? 1 : 0;
            if (!dev_started) begin
                if (mosi === 1'b1) dev_started = 1'b1;
            end else if (dev_nb < 4) begin
                dev_addr = {dev_addr[2:0], mosi};
                dev_nb++;
            end else if (mosi !== 1'b0) begin
                dev_extra++;
            end
        end
    end

    always @(negedge sclk) begin
        if (cs_n === 1'b0 && dev_nb == 4) begin
            dev_falls++;
            if (dev_falls == 1)       miso = 1'b0;
            else if (dev_falls <= 9)  miso = dev_code[9 - dev_falls];
            else if (dev_falls <= 16) miso = dev_code[dev_falls - 9] ^ (dev_corrupt && dev_falls == 12);
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    // One read, compared against a cycle-counted model on every clock.
    task automatic run_conv(input logic [1:0] ch, input logic dm, input logic [7:0] code,
                            input bit corrupt, input bit poke);
        integer cs_err = 0, sclk_err = 0, busy_err = 0, val_err = 0, mosi_err = 0;
        logic prev_sclk = 1'b0, prev_mosi = 1'b0;
        integer opens0;
        logic [3:0] exp_addr;
        exp_addr   = {~dm, ch[0], ch[1], 1'b0};
        dev_code    = code;
        dev_corrupt = corrupt;
        opens0      = dev_opens;
        dev_extra   = 0;
        @(negedge clk);
        chan = ch; diff_mode = dm; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int cyc = 0; cyc <= DONE_C + 1; cyc++) begin
            if ((cyc < FRAME_C) !== (cs_n === 1'b0)) cs_err++;
            if ((sclk === 1'b1) !== ((cyc < FRAME_C) && (((cyc / H) % 2) == 1))) sclk_err++;
            if ((busy === 1'b1) !== (cyc <= DONE_C)) busy_err++;
            if ((result_valid === 1'b1) !== (cyc == DONE_C)) val_err++;
            if (prev_sclk && sclk === 1'b1 && mosi !== prev_mosi) mosi_err++;
            if (cyc == DONE_C) begin
                check("R7 result", result, code);
                check("R8 mismatch", mismatch, corrupt);
            end
            if (cyc == DONE_C + 1) begin
                check("R10 result held", result, code);
                check("R10 mismatch held", mismatch, corrupt);
            end
            prev_sclk = sclk;
            prev_mosi = mosi;
            if (poke) req = (cyc == 500);
            if (poke && cyc == 500) begin chan = ~ch; diff_mode = ~dm; end
            @(negedge clk);
        end
        req = 1'b0;
        check("R9 cs_n waveform", cs_err, 0);
        check("R3 sclk waveform", sclk_err, 0);
        check("R2 busy window", busy_err, 0);
        check("R10 valid pulse", val_err, 0);
        check("R4 mosi steady while sclk high", mosi_err, 0);
        check("R4 start bit in slot 0", dev_first_rise, 1);
        check("R4 mosi zero after command", dev_extra, 0);
        check("R2 one frame per accepted request", dev_opens - opens0, 1);
        if (dm) check("R6 differential selection word", dev_addr, exp_addr);
        else    check("R5 single-ended selection word", dev_addr, exp_addr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cs_n in reset", cs_n, 1);
        check("R1 sclk in reset", sclk, 0);
        check("R1 mosi in reset", mosi, 0);
        check("R1 busy in reset", busy, 0);
        check("R1 valid in reset", result_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 cs_n idle", cs_n, 1);
        check("R1 busy idle", busy, 0);

        run_conv(2'd0, 1'b0, 8'hA5, 1'b0, 1'b0);
        run_conv(2'd3, 1'b0, 8'h3C, 1'b0, 1'b0);
        run_conv(2'd2, 1'b0, 8'h5E, 1'b0, 1'b1);  // R2: request while busy ignored
        run_conv(2'd0, 1'b1, 8'hFF, 1'b0, 1'b0);
        run_conv(2'd3, 1'b1, 8'h00, 1'b0, 1'b0);
        run_conv(2'd1, 1'b1, 8'h96, 1'b1, 1'b0);  // R8: corrupted replay
        run_conv(2'd1, 1'b0, 8'h81, 1'b0, 1'b0);
        run_conv(2'd2, 1'b1, 8'h7E, 1'b1, 1'b0);

        summary();
        $finish;
    end

endmodule